// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts activity inside an accelerator for profiling software. It holds a set of 32-bit event counters and one 48-bit cycle counter. Each event counter is tied by a type register to one of the event input lines. The cycle counter counts clock cycles. Its counting window can be opened by one selected event and closed by another. When a counter wraps, a sticky overflow flag is set. The single interrupt line reports any overflow flag whose interrupt enable is set.

Software reaches the block over a plain 32-bit register bus with write and read strobes. Enable, overflow and interrupt-enable state each sit behind a pair of addresses. One address sets bits on a written 1 and the other clears them. Both use the same bit map: bit k is event counter k and bit 31 is the cycle counter. Software can also bump chosen counters by one through a mask register.

Top module: `perf_mon`

## Requirements
- R1: After reset every counter, enable, overflow, interrupt-enable, type and configuration register is zero and `irq` is low. The control register at 0x180 reads back the number of event counters in bits 15:11 and the global enable in bit 0. Read data appears on `rdata` in the cycle after `rd_en`.
- R2: Writing 1s to 0x184 enables those counters and writing 1s to 0x188 disables them. Reading either address returns the enable mask. Only bits 0 to NUM_CNT-1 and bit 31 are stored.
- R3: Event counter k (value at 0x300+4k, type at 0x380+4k, type in bits 9:0) adds one in each cycle where its selected input is high, provided bit 0 of 0x180 and enable bit k are both set. Type n (1 to NUM_EVT) selects `evt_in[n-1]`. Type 0 or a type above NUM_EVT counts nothing, and so does a disabled counter.
- R4: A write to a counter address loads that counter. Writing 1 to bit 1 of 0x180 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 read back as 0.
- R5: A counter that adds one at its maximum value wraps to zero and sets its overflow flag on the same clock edge.
- R6: Reading 0x18C returns the overflow flags. Writing 1s to 0x18C sets flags and writing 1s to 0x190 clears them. A flag stays set until it is cleared, and a wrap in the same cycle as a clear leaves the flag set.
- R7: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set. Interrupt enables are set at 0x194 and cleared at 0x198, and reading 0x194 returns the mask.
- R8: The cycle counter is 48 bits wide. Its low word is at 0x1A0 and bits 47:32 are at 0x1A4 (bits 15:0). It adds one per cycle while it is enabled (bit 31 and the global enable) and its window is open. It carries from the low word into the high word and wraps at 2^48.
- R9: At 0x1A8, bits 9:0 give the start event and bits 25:16 give the stop event, numbered as in R3. A start value of 0 keeps the window always open. Otherwise the start event opens the window from the next cycle, and the stop event closes it after the cycle in which it occurs. Stop wins when both occur together.
- R10: Writing a mask to 0x1AC adds one to every selected counter that is enabled and under the global enable. Other counters are unchanged. A counter never adds more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| evt_in | input | NUM_EVT | Event lines from the accelerator |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The bench builds the unit with four event counters and only four event lines. This makes every type code reachable, including the zero code and an out-of-range code. A six-round sweep turns each counter through all of these codes while the enable masks alternate, and it computes the expected counts from the stimulus patterns. The cycle counter is preloaded near 2^32 and near 2^48, which brings the word carry and the full wrap into a few cycles.

// File: rtl/perf_mon.sv
module perf_mon #(
  parameter int NUM_CNT   = 4,
  parameter int CNT_W     = 32,
  parameter int CYC_W     = 48,
  parameter int NUM_EVT   = 16,
  parameter int EVT_NUM_W = 10,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic              irq
);
  localparam int A_CTRL = 'h180, A_ENSET = 'h184, A_ENCLR = 'h188;
  localparam int A_OVSET = 'h18C, A_OVCLR = 'h190, A_IESET = 'h194, A_IECLR = 'h198;
  localparam int A_CYLO = 'h1A0, A_CYHI = 'h1A4, A_CYCFG = 'h1A8, A_SWINC = 'h1AC;
  localparam int A_CNT = 'h300, A_TYPE = 'h380;
  localparam int HI_W = CYC_W - 32;
  localparam logic [31:0] MASK = 32'h8000_0000 | ((32'h1 << NUM_CNT) - 32'h1);

  logic glob_en, run;
  logic [31:0] en, ovf, ie;
  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic [EVT_NUM_W-1:0] etype [NUM_CNT];
  logic [EVT_NUM_W-1:0] cfg_start, cfg_stop;
  logic [CYC_W-1:0] cyc;
  logic [NUM_CNT-1:0] bump, wrap_evt;
  logic cyc_bump, cyc_wrap, cyc_load;

  function automatic logic hit(input logic [EVT_NUM_W-1:0] n, input logic [NUM_EVT-1:0] e);
    int idx;
    idx = int'(n) - 1;
    if (idx < 0 || idx >= NUM_EVT) return 1'b0;
    return e[idx];
  endfunction

  function automatic logic wr_at(input int a);
    return wr_en && (addr == ADDR_W'(a));
  endfunction

  logic [31:0] sw, ovf_hit;
  logic clr_evt, clr_cyc;
  assign sw      = wr_at(A_SWINC) ? (wdata & MASK) : '0;
  assign clr_evt = wr_at(A_CTRL) & wdata[1];
  assign clr_cyc = wr_at(A_CTRL) & wdata[2];
  assign ovf_hit = {cyc_wrap, {(31-NUM_CNT){1'b0}}, wrap_evt};

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic load;
    assign load        = wr_at(A_CNT + 4*k);
    assign bump[k]     = glob_en & en[k] & (hit(etype[k], evt_in) | sw[k]);
    assign wrap_evt[k] = bump[k] & ~load & ~clr_evt & (&cnt[k]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt[k] <= '0;
      else if (load)    cnt[k] <= wdata[CNT_W-1:0];
      else if (clr_evt) cnt[k] <= '0;
      else if (bump[k]) cnt[k] <= cnt[k] + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                    etype[k] <= '0;
      else if (wr_at(A_TYPE + 4*k))  etype[k] <= wdata[EVT_NUM_W-1:0];

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(glob_en) && !$past(wr_en)) |-> $stable(cnt[k]));
  end

  assign cyc_load = wr_at(A_CYLO) | wr_at(A_CYHI) | clr_cyc;
  assign cyc_bump = glob_en & en[31] & ((cfg_start == '0) | run | sw[31]);
  assign cyc_wrap = cyc_bump & ~cyc_load & (&cyc);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cyc <= '0;
    else if (wr_at(A_CYLO))  cyc <= {cyc[CYC_W-1:32], wdata};
    else if (wr_at(A_CYHI))  cyc <= {wdata[HI_W-1:0], cyc[31:0]};
    else if (clr_cyc)        cyc <= '0;
    else if (cyc_bump)       cyc <= cyc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     run <= 1'b0;
    else if (hit(cfg_stop, evt_in)) run <= 1'b0;
    else if (hit(cfg_start, evt_in)) run <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      glob_en <= 1'b0; en <= '0; ovf <= '0; ie <= '0;
      cfg_start <= '0; cfg_stop <= '0;
    end else begin
      if (wr_at(A_CTRL)) glob_en <= wdata[0];
      if (wr_at(A_ENSET)) en <= en | (wdata & MASK);
      if (wr_at(A_ENCLR)) en <= en & ~(wdata & MASK);
      if (wr_at(A_IESET)) ie <= ie | (wdata & MASK);
      if (wr_at(A_IECLR)) ie <= ie & ~(wdata & MASK);
      ovf <= (ovf & ~(wr_at(A_OVCLR) ? wdata : 32'h0))
             | (wr_at(A_OVSET) ? (wdata & MASK) : 32'h0) | ovf_hit;
      if (wr_at(A_CYCFG)) begin
        cfg_start <= wdata[EVT_NUM_W-1:0];
        cfg_stop  <= wdata[16 +: EVT_NUM_W];
      end
    end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (int'(addr))
      A_CTRL:           rd_mux = {16'h0, 5'(NUM_CNT), 10'h0, glob_en};
      A_ENSET, A_ENCLR: rd_mux = en;
      A_OVSET:          rd_mux = ovf;
      A_IESET:          rd_mux = ie;
      A_CYLO:           rd_mux = cyc[31:0];
      A_CYHI:           rd_mux = 32'(cyc[CYC_W-1:32]);
      A_CYCFG:          rd_mux = {6'h0, cfg_stop, 6'h0, cfg_start};
      default:          rd_mux = '0;
    endcase
    for (int k = 0; k < NUM_CNT; k++) begin
      if (int'(addr) == A_CNT + 4*k)  rd_mux = 32'(cnt[k]);
      if (int'(addr) == A_TYPE + 4*k) rd_mux = 32'(etype[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;

  assign irq = |(ovf & ie);

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_at(A_OVCLR) || wr_at(A_IECLR)));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ovf) & ~ovf)) |-> $past(wr_at(A_OVCLR)));
  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_at(A_ENSET) || wr_at(A_ENCLR)) |-> $stable(en));
  // R8
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(glob_en && en[31] && cfg_start == '0) && !$past(wr_en))
      |-> cyc == $past(cyc) + 1'b1);
endmodule

// File: tb/perf_mon_tb.sv
module perf_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int CTRL = 'h180, ENSET = 'h184, ENCLR = 'h188, OVSET = 'h18C, OVCLR = 'h190;
  localparam int IESET = 'h194, IECLR = 'h198, CYLO = 'h1A0, CYHI = 'h1A4, CYCFG = 'h1A8;
  localparam int SWINC = 'h1AC, CNT = 'h300, TYP = 'h380;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, d;
  logic [NE-1:0] evt_in = '0;
  int checks = 0, fails = 0;

  perf_mon #(.NUM_EVT(NE)) dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    wr_en = 1; addr = 12'(a); wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rd_en = 1; addr = 12'(a);
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [NE-1:0] pat(input int i, input int r);
    return NE'(((i*5 + r*3) ^ (i >> 2)));
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(CTRL, d);  chk("R1 ctrl", d, 32'h2000);
    rd(ENSET, d); chk("R1 en", d, 0);
    rd(CNT+8, d); chk("R1 cnt2", d, 0);
    rd(CYLO, d);  chk("R1 cyc", d, 0);
    // R2 set/clear enables
    wr(ENSET, 32'hFFFF_FFFF); rd(ENSET, d); chk("R2 set", d, 32'h8000_000F);
    wr(ENCLR, 32'h0000_0005); rd(ENCLR, d); chk("R2 clr", d, 32'h8000_000A);
    // R4 load and strobes
    wr(CNT+8, 32'h1234); rd(CNT+8, d); chk("R4 load", d, 32'h1234);
    wr(CTRL, 32'h7); rd(CTRL, d); chk("R4 ctrl rb", d, 32'h2001);
    wr(CTRL, 0);
    rd(CNT+8, d); chk("R4 evt clear", d, 0);
    // R3 sweep over types and enable masks
    for (int r = 0; r < 6; r++) begin
      int len, exp;
      logic [31:0] m;
      len = 12 + 3*r;
      m = 32'h8000_0000 | ((r % 2) ? 32'hF : 32'h5);
      wr(CTRL, 32'h6);
      wr(ENCLR, 32'hFFFF_FFFF); wr(ENSET, m);
      for (int k = 0; k < 4; k++) wr(TYP + 4*k, 32'((r + k) % 6));
      wr(CTRL, 1);
      for (int i = 0; i < len; i++) begin evt_in = pat(i, r); @(negedge clk); end
      evt_in = 0;
      wr(CTRL, 0);
      for (int k = 0; k < 4; k++) begin
        int t;
        t = (r + k) % 6;
        exp = 0;
        if (m[k] && t >= 1 && t <= NE)
          for (int i = 0; i < len; i++) exp += int'(pat(i, r)[t-1]);
        rd(CNT + 4*k, d); chk($sformatf("R3 round %0d cnt%0d", r, k), d, 32'(exp));
      end
      rd(CYLO, d); chk($sformatf("R8 round %0d cycles", r), d, 32'(len + 1));
    end
    // R5 wrap with R7 interrupt
    wr(CTRL, 32'h6);
    wr(TYP, 1); wr(ENCLR, 32'hFFFF_FFFF); wr(ENSET, 1); wr(IESET, 1);
    wr(CNT, 32'hFFFF_FFFE);
    wr(CTRL, 1);
    evt_in = 1; idle(2); evt_in = 0;
    wr(CTRL, 0);
    rd(CNT, d);   chk("R5 wrapped", d, 0);
    rd(OVSET, d); chk("R5 ovf flag", d, 1);
    chk("R7 irq on", 32'(irq), 1);
    idle(3); chk("R7 irq held", 32'(irq), 1);
    wr(OVCLR, 1); chk("R6 cleared irq", 32'(irq), 0);
    rd(OVSET, d); chk("R6 clr", d, 0);
    // R6/R7 masking
    wr(OVSET, 32'h8000_0000); rd(OVSET, d); chk("R6 set", d, 32'h8000_0000);
    chk("R7 masked", 32'(irq), 0);
    wr(IESET, 32'h8000_0000); chk("R7 unmasked", 32'(irq), 1);
    rd(IESET, d); chk("R7 ie mask", d, 32'h8000_0001);
    wr(IECLR, 32'hFFFF_FFFF); chk("R7 ie clr", 32'(irq), 0);
    wr(OVCLR, 32'hFFFF_FFFF);
    // R8 carry and 48-bit wrap
    wr(ENSET, 32'h8000_0000);
    wr(CYLO, 32'hFFFF_FFFF); wr(CYHI, 32'h12);
    wr(CTRL, 1); wr(CTRL, 0);
    rd(CYLO, d); chk("R8 lo carry", d, 0);
    rd(CYHI, d); chk("R8 hi carry", d, 32'h13);
    wr(CYLO, 32'hFFFF_FFFD); wr(CYHI, 32'hABCD_FFFF);
    rd(CYHI, d); chk("R8 hi width", d, 32'hFFFF);
    wr(CTRL, 1); idle(2); wr(CTRL, 0);
    rd(CYLO, d); chk("R8 wrap lo", d, 0);
    rd(CYHI, d); chk("R8 wrap hi", d, 0);
    rd(OVSET, d); chk("R8 wrap ovf", d, 32'h8000_0000);
    wr(OVCLR, 32'hFFFF_FFFF);
    // R9 start/stop window
    wr(CYCFG, 32'h0002_0001); wr(CTRL, 32'h4);
    wr(CTRL, 1); idle(3);
    evt_in = 1; idle(1); evt_in = 0; idle(4);
    evt_in = 2; idle(1); evt_in = 0; idle(3);
    wr(CTRL, 0);
    rd(CYLO, d); chk("R9 window", d, 5);
    rd(CYCFG, d); chk("R9 cfg rb", d, 32'h0002_0001);
    // R10 software increment
    wr(CYCFG, 0); wr(CTRL, 32'h6);
    for (int k = 0; k < 4; k++) wr(TYP + 4*k, 0);
    wr(ENCLR, 32'hFFFF_FFFF); wr(ENSET, 32'h0000_0005);
    wr(CTRL, 1); wr(SWINC, 32'h8000_000F); wr(CTRL, 0);
    for (int k = 0; k < 4; k++) begin
      rd(CNT + 4*k, d); chk($sformatf("R10 cnt%0d", k), d, (k % 2) ? 0 : 1);
    end
    wr(SWINC, 32'hF);
    rd(CNT, d); chk("R10 global off", d, 1);
    wr(TYP, 1); wr(CTRL, 1);
    evt_in = 1; wr(SWINC, 1); evt_in = 0;
    wr(CTRL, 0);
    rd(CNT, d); chk("R10 single step", d, 2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule